// File: doc/BRIEF.md
# Address Window Access Filter

This block screens every physical access against a small set of programmable address windows. The top byte of the access address and the privilege level of the access are checked against each window. Each window holds an enable, an 8-bit base, an 8-bit don't-care mask, a privilege selector, a cache mode, a write-protect flag and two page attribute bits. All windows are evaluated in parallel. The lowest-numbered matching window decides the attributes driven out for the access.

Software or a boot sequencer loads a window through a single-cycle write port, which has one field input per window setting. The result of a lookup appears one clock after the request strobe: a valid flag, a hit flag, the selected cache mode, the two page attribute bits and an abort flag. The abort flag is raised for a store to a protected window. The page attribute bits are never decoded here. They are passed through for the bus to use.

Top module: `awc_unit`

## Requirements
- R1: After reset, all windows are disabled and every result output is 0, so any access misses.
- R2: Only address bits [31:24] are compared with a window's base. Bits [23:0] never affect the match.
- R3: A mask bit set to 1 removes the matching base bit from the comparison. Mask 8'h0F on base 8'h80 therefore matches top bytes 8'h80 to 8'h8F and nothing else.
- R4: A window whose enable is 0 never matches, whatever its other settings.
- R5: The privilege selector matches as follows: 2'b00 matches user accesses only (acc_super = 0), 2'b01 matches supervisor accesses only (acc_super = 1), and 2'b1x matches both.
- R6: Access kind 2'b01 is a write and 2'b10 is a read-modify-write. Either kind, when it hits a window with write-protect set, gives res_abort = 1. Kind 2'b00 (read) and kind 2'b11 (treated as a read) never abort.
- R7: On a hit, res_cmode and res_upa carry the winning window's cache mode and page attribute bits unchanged. The cache mode codes are 00 cachable write-through, 01 cachable copyback, 10 noncachable serialized and 11 noncachable.
- R8: When several windows match, window 0 (the lowest index) supplies the cache mode, the attributes and the protection decision.
- R9: On a miss, res_hit = 0, res_abort = 0, res_cmode = 2'b00 and res_upa = 2'b00.
- R10: Results are registered. A request sampled at clock edge N drives res_valid = 1 after edge N. A cycle without a request drives all result outputs to 0 after the next edge.
- R11: A configuration write and a lookup in the same cycle: the lookup uses the window contents from before the write. The new contents apply from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the window selected by cfg_idx |
| cfg_idx | input | 1 | Window index to load |
| cfg_en | input | 1 | Window enable |
| cfg_base | input | 8 | Base value for address bits [31:24] |
| cfg_mask | input | 8 | Don't-care mask for the base |
| cfg_priv | input | 2 | Privilege selector |
| cfg_cmode | input | 2 | Cache mode |
| cfg_wp | input | 1 | Write-protect flag |
| cfg_upa | input | 2 | Page attribute bits |
| acc_req | input | 1 | Access request strobe |
| acc_addr | input | 32 | Physical access address |
| acc_super | input | 1 | 1 = supervisor access, 0 = user access |
| acc_kind | input | 2 | Access kind: read, write, read-modify-write |
| res_valid | output | 1 | Result belongs to the previous cycle's request |
| res_hit | output | 1 | An enabled window matched |
| res_cmode | output | 2 | Selected cache mode |
| res_upa | output | 2 | Selected page attribute bits |
| res_abort | output | 1 | Access error for a protected store |

## Verification
A window update and a lookup can arrive in the same clock. The bench drives cfg_we and acc_req on the same falling edge. In one case it enables a window that the probed address falls in. In another it clears the write-protect of a window that a store hits. The result of that lookup must reflect the settings from before the update. The next lookup must reflect the new settings.

// File: rtl/awc_pkg.sv
package awc_pkg;

    localparam int TAG_W = 8;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_RMW   = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        CM_WRTHRU = 2'b00,
        CM_COPYBK = 2'b01,
        CM_NC_SER = 2'b10,
        CM_NC     = 2'b11
    } cmode_e;

    typedef struct packed {
        logic             en;
        logic [TAG_W-1:0] base;
        logic [TAG_W-1:0] mask;
        logic [1:0]       priv;
        cmode_e           cmode;
        logic             wp;
        logic [1:0]       upa;
    } win_cfg_t;

endpackage

// File: rtl/awc_window_match.sv
module awc_window_match
    import awc_pkg::*;
(
    input  win_cfg_t         cfg,
    input  logic [TAG_W-1:0] tag,
    input  logic             super_mode,
    output logic             hit
);

    logic priv_ok;
    logic addr_ok;

    always_comb begin
        priv_ok = cfg.priv[1] | (cfg.priv[0] == super_mode);
        addr_ok = ((tag ^ cfg.base) & ~cfg.mask) == '0;
        hit     = cfg.en & priv_ok & addr_ok;
    end

endmodule

// File: rtl/awc_prio_pick.sv
module awc_prio_pick #(
    parameter  int N     = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/awc_unit.sv
module awc_unit
    import awc_pkg::*;
#(
    parameter  int NUM_WIN = 2,
    parameter  int ADDR_W  = 32,
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [TAG_W-1:0]  cfg_base,
    input  logic [TAG_W-1:0]  cfg_mask,
    input  logic [1:0]        cfg_priv,
    input  logic [1:0]        cfg_cmode,
    input  logic              cfg_wp,
    input  logic [1:0]        cfg_upa,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_super,
    input  logic [1:0]        acc_kind,
    output logic              res_valid,
    output logic              res_hit,
    output logic [1:0]        res_cmode,
    output logic [1:0]        res_upa,
    output logic              res_abort
);

    typedef struct packed {
        win_cfg_t [NUM_WIN-1:0] win;
        logic                   vld;
        logic                   hit;
        logic                   abort;
        cmode_e                 cmode;
        logic [1:0]             upa;
    } state_t;

    state_t s_d, s_q;

    logic [TAG_W-1:0]   tag;
    logic [NUM_WIN-1:0] win_hit;
    logic               any_hit;
    logic [IDX_W-1:0]   pick;
    logic               is_store;

    assign tag      = acc_addr[ADDR_W-1 -: TAG_W];
    assign is_store = (acc_kind_e'(acc_kind) == ACC_WRITE) ||
                      (acc_kind_e'(acc_kind) == ACC_RMW);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        awc_window_match u_match (
            .cfg        (s_q.win[g]),
            .tag        (tag),
            .super_mode (acc_super),
            .hit        (win_hit[g])
        );
    end

    awc_prio_pick #(.N(NUM_WIN)) u_pick (
        .hits (win_hit),
        .any  (any_hit),
        .idx  (pick)
    );

    always_comb begin
        s_d       = s_q;
        s_d.vld   = 1'b0;
        s_d.hit   = 1'b0;
        s_d.abort = 1'b0;
        s_d.cmode = CM_WRTHRU;
        s_d.upa   = 2'b00;

        if (acc_req) begin
            s_d.vld = 1'b1;
            if (any_hit) begin
                s_d.hit   = 1'b1;
                s_d.cmode = s_q.win[pick].cmode;
                s_d.upa   = s_q.win[pick].upa;
                s_d.abort = s_q.win[pick].wp & is_store;
            end
        end

        if (cfg_we && (int'(cfg_idx) < NUM_WIN)) begin
            s_d.win[cfg_idx].en    = cfg_en;
            s_d.win[cfg_idx].base  = cfg_base;
            s_d.win[cfg_idx].mask  = cfg_mask;
            s_d.win[cfg_idx].priv  = cfg_priv;
            s_d.win[cfg_idx].cmode = cmode_e'(cfg_cmode);
            s_d.win[cfg_idx].wp    = cfg_wp;
            s_d.win[cfg_idx].upa   = cfg_upa;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign res_valid = s_q.vld;
    assign res_hit   = s_q.hit;
    assign res_cmode = s_q.cmode;
    assign res_upa   = s_q.upa;
    assign res_abort = s_q.abort;

endmodule

// File: rtl/awc_unit_chk.sv
module awc_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_req,
    input logic [1:0] acc_kind,
    input logic       res_valid,
    input logic       res_hit,
    input logic [1:0] res_cmode,
    input logic [1:0] res_upa,
    input logic       res_abort
);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> res_valid); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> (!res_valid && !res_hit && !res_abort &&
                      res_cmode == 2'b00 && res_upa == 2'b00)); // R10

    AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_cmode == 2'b00 && res_upa == 2'b00 && !res_abort)); // R9

    AST_READ_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && (acc_kind == 2'b00 || acc_kind == 2'b11)) |=> !res_abort); // R6

endmodule

bind awc_unit awc_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_req   (acc_req),
    .acc_kind  (acc_kind),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_cmode (res_cmode),
    .res_upa   (res_upa),
    .res_abort (res_abort)
);

// File: tb/awc_unit_test.sv
module awc_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic [7:0]  cfg_base = '0;
    logic [7:0]  cfg_mask = '0;
    logic [1:0]  cfg_priv = '0;
    logic [1:0]  cfg_cmode = '0;
    logic        cfg_wp = 1'b0;
    logic [1:0]  cfg_upa = '0;
    logic        acc_req = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_super = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        res_valid, res_hit, res_abort;
    logic [1:0]  res_cmode, res_upa;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    awc_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .cfg_priv(cfg_priv), .cfg_cmode(cfg_cmode), .cfg_wp(cfg_wp),
        .cfg_upa(cfg_upa), .acc_req(acc_req), .acc_addr(acc_addr),
        .acc_super(acc_super), .acc_kind(acc_kind), .res_valid(res_valid),
        .res_hit(res_hit), .res_cmode(res_cmode), .res_upa(res_upa),
        .res_abort(res_abort)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic expect_res(input string req, input logic hit,
                              input logic [1:0] cm, input logic [1:0] upa,
                              input logic ab);
        chk(req, "valid", {7'd0, res_valid}, 8'd1);
        chk(req, "hit",   {7'd0, res_hit},   {7'd0, hit});
        chk(req, "cmode", {6'd0, res_cmode}, {6'd0, cm});
        chk(req, "upa",   {6'd0, res_upa},   {6'd0, upa});
        chk(req, "abort", {7'd0, res_abort}, {7'd0, ab});
    endtask

    task automatic set_win(input logic idx, input logic en, input logic [7:0] base,
                           input logic [7:0] mask, input logic [1:0] priv,
                           input logic [1:0] cm, input logic wp, input logic [1:0] upa);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_en = en; cfg_base = base;
        cfg_mask = mask; cfg_priv = priv; cfg_cmode = cm; cfg_wp = wp; cfg_upa = upa;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic sup, input logic [1:0] k);
        @(negedge clk);
        acc_req = 1'b1; acc_addr = a; acc_super = sup; acc_kind = k;
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "valid after reset", {7'd0, res_valid}, 8'd0);
        chk("R1", "hit after reset",   {7'd0, res_hit},   8'd0);
        chk("R1", "abort after reset", {7'd0, res_abort}, 8'd0);
        probe(32'h0000_0000, 1'b1, 2'b01);
        expect_res("R1", 1'b0, 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_tag;
        set_win(1'b0, 1'b1, 8'h40, 8'h00, 2'b10, 2'b01, 1'b0, 2'b10);
        probe(32'h40FF_FFFF, 1'b0, 2'b00);
        expect_res("R2", 1'b1, 2'b01, 2'b10, 1'b0);
        probe(32'h4000_0000, 1'b1, 2'b00);
        expect_res("R2", 1'b1, 2'b01, 2'b10, 1'b0);
        probe(32'h4100_0000, 1'b0, 2'b00);
        expect_res("R9", 1'b0, 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_mask;
        set_win(1'b1, 1'b1, 8'h80, 8'h0F, 2'b11, 2'b10, 1'b0, 2'b01);
        probe(32'h8F12_3456, 1'b0, 2'b00);
        expect_res("R3", 1'b1, 2'b10, 2'b01, 1'b0);
        probe(32'h8000_0000, 1'b1, 2'b00);
        expect_res("R3", 1'b1, 2'b10, 2'b01, 1'b0);
        probe(32'h9000_0000, 1'b0, 2'b00);
        expect_res("R3", 1'b0, 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_priv;
        set_win(1'b1, 1'b1, 8'h80, 8'h0F, 2'b00, 2'b10, 1'b0, 2'b01);
        probe(32'h8100_0000, 1'b0, 2'b00);
        expect_res("R5", 1'b1, 2'b10, 2'b01, 1'b0);
        probe(32'h8100_0000, 1'b1, 2'b00);
        expect_res("R5", 1'b0, 2'b00, 2'b00, 1'b0);
        set_win(1'b1, 1'b1, 8'h80, 8'h0F, 2'b01, 2'b10, 1'b0, 2'b01);
        probe(32'h8100_0000, 1'b0, 2'b00);
        expect_res("R5", 1'b0, 2'b00, 2'b00, 1'b0);
        probe(32'h8100_0000, 1'b1, 2'b00);
        expect_res("R5", 1'b1, 2'b10, 2'b01, 1'b0);
    endtask

    task automatic t_disable;
        set_win(1'b1, 1'b0, 8'h80, 8'hFF, 2'b11, 2'b11, 1'b1, 2'b11);
        probe(32'h8100_0000, 1'b1, 2'b01);
        expect_res("R4", 1'b0, 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_protect;
        set_win(1'b0, 1'b1, 8'h40, 8'h00, 2'b11, 2'b00, 1'b1, 2'b01);
        probe(32'h4000_1000, 1'b1, 2'b01);
        expect_res("R6", 1'b1, 2'b00, 2'b01, 1'b1);
        probe(32'h4000_1000, 1'b0, 2'b10);
        expect_res("R6", 1'b1, 2'b00, 2'b01, 1'b1);
        probe(32'h4000_1000, 1'b1, 2'b00);
        expect_res("R6", 1'b1, 2'b00, 2'b01, 1'b0);
        probe(32'h4000_1000, 1'b1, 2'b11);
        expect_res("R6", 1'b1, 2'b00, 2'b01, 1'b0);
    endtask

    task automatic t_cmodes;
        for (int m = 0; m < 4; m++) begin
            set_win(1'b0, 1'b1, 8'h22, 8'h00, 2'b11, 2'(m), 1'b0, 2'(3 - m));
            probe(32'h2200_0000, 1'b0, 2'b00);
            expect_res("R7", 1'b1, 2'(m), 2'(3 - m), 1'b0);
        end
    endtask

    task automatic t_prio;
        set_win(1'b0, 1'b1, 8'h40, 8'h00, 2'b11, 2'b01, 1'b1, 2'b10);
        set_win(1'b1, 1'b1, 8'h40, 8'h0F, 2'b11, 2'b11, 1'b0, 2'b11);
        probe(32'h4000_0000, 1'b1, 2'b01);
        expect_res("R8", 1'b1, 2'b01, 2'b10, 1'b1);
        probe(32'h4300_0000, 1'b1, 2'b01);
        expect_res("R8", 1'b1, 2'b11, 2'b11, 1'b0);
        set_win(1'b0, 1'b0, 8'h40, 8'h00, 2'b11, 2'b01, 1'b1, 2'b10);
        probe(32'h4000_0000, 1'b1, 2'b01);
        expect_res("R8", 1'b1, 2'b11, 2'b11, 1'b0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        acc_req = 1'b1; acc_addr = 32'h4000_0000; acc_super = 1'b0; acc_kind = 2'b00;
        #1;
        chk("R10", "valid before edge", {7'd0, res_valid}, 8'd0);
        @(negedge clk);
        acc_req = 1'b0;
        chk("R10", "valid after edge", {7'd0, res_valid}, 8'd1);
        chk("R10", "hit after edge", {7'd0, res_hit}, 8'd1);
        @(negedge clk);
        chk("R10", "idle valid", {7'd0, res_valid}, 8'd0);
        chk("R10", "idle hit",   {7'd0, res_hit},   8'd0);
        chk("R10", "idle cmode", {6'd0, res_cmode}, 8'd0);
        chk("R10", "idle upa",   {6'd0, res_upa},   8'd0);
    endtask

    task automatic t_same_cycle;
        set_win(1'b0, 1'b0, 8'h20, 8'h00, 2'b11, 2'b01, 1'b0, 2'b01);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 1'b0; cfg_en = 1'b1; cfg_base = 8'h20;
        cfg_mask = 8'h00; cfg_priv = 2'b11; cfg_cmode = 2'b01; cfg_wp = 1'b1; cfg_upa = 2'b01;
        acc_req = 1'b1; acc_addr = 32'h2000_0000; acc_super = 1'b0; acc_kind = 2'b01;
        @(negedge clk);
        cfg_we = 1'b0; acc_req = 1'b0;
        expect_res("R11", 1'b0, 2'b00, 2'b00, 1'b0);
        probe(32'h2000_0000, 1'b0, 2'b01);
        expect_res("R11", 1'b1, 2'b01, 2'b01, 1'b1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wp = 1'b0;
        acc_req = 1'b1; acc_kind = 2'b10;
        @(negedge clk);
        cfg_we = 1'b0; acc_req = 1'b0;
        expect_res("R11", 1'b1, 2'b01, 2'b01, 1'b1);
        probe(32'h2000_0000, 1'b0, 2'b10);
        expect_res("R11", 1'b1, 2'b01, 2'b01, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tag();
        t_mask();
        t_priv();
        t_disable();
        t_protect();
        t_cmodes();
        t_prio();
        t_timing();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule